// File: doc/BRIEF.md
# Non-Audio Burst and Block Detector

This block sits behind a digital audio receiver's decoder and watches the stream of received subframe samples. Each sample arrives with a tag that says whether it belongs to the first (A) or second (B) subframe of a frame. A further tag marks the frame that opens a 192-frame channel-status block. The block also receives the channel-status bit of each subframe. Samples leave the block one cycle later with their data unchanged.

A six-state sync machine compares the top 16 bits of each incoming sample against a fixed 96-bit burst marker. The marker is four zero words followed by 0xF872 and then 0x4E1F. A full match starts a hold timer of HOLD_FRAMES frames, and the burst flag stays up while that timer runs. The reported non-audio status is the burst flag ORed with channel-status bit 1 of the channel picked by a select input.

A three-state block machine turns each block-opening mark into a window. The window opens BLK_DELAY frames after the mark and stays open for BLK_LEN frames.

The sync machine has these states: SY_IDLE (hunting for the first zero word), SY_Z1, SY_Z2 and SY_Z3 (one, two or three zero words seen), SY_Z4 (four zeros seen, waiting for 0xF872) and SY_M1 (waiting for 0x4E1F). A matching word moves the machine one state forward. A 0x4E1F in SY_M1 signals a hit and returns the machine to SY_IDLE. A word that does not match sends the machine to SY_Z1 if that word is zero, and to SY_IDLE otherwise.

The block machine has these states: BK_IDLE, BK_WAIT (counting the delay frames) and BK_OPEN (window high). A block mark moves the machine to BK_WAIT from any state. BK_WAIT moves to BK_OPEN on the BLK_DELAY-th frame. BK_OPEN returns to BK_IDLE on the BLK_LEN-th frame.

Top module: `nab_detector`

## Requirements
- R1: Every valid input sample appears on `out_data` with `out_valid` high exactly one cycle later, with unchanged data. When `in_valid` is low, `out_valid` is low one cycle later.
- R2: Six consecutive valid samples whose bits [23:8] are 0x0000, 0x0000, 0x0000, 0x0000, 0xF872 and 0x4E1F, in that order, raise `burst_det` in the cycle after the sixth sample. The A/B tag plays no part in the match.
- R3: A word that breaks the sequence restarts the search. Only that word is tested again, as a possible first (zero) word. So five zero words followed by 0xF872, 0x4E1F give no match, while a broken attempt followed by a clean six-word sequence does match.
- R4: A frame is counted on each valid subframe-A sample (`in_chan_b`=0). After a match, `burst_det` stays high through HOLD_FRAMES - 1 such frames without a new match. It drops after the HOLD_FRAMES-th such frame.
- R5: Each new match reloads the hold timer to its full value of HOLD_FRAMES frames, even while `burst_det` is already high.
- R6: `nonaudio` equals `burst_det` OR the most recently captured channel-status bit 1.
- R7: A frame whose subframe-A sample has `in_zpre`=1 is frame 0 of a block. Channel-status bit 1 is the `in_cs` value of frame 1, taken from subframe A when `cs_sel`=0 and from subframe B when `cs_sel`=1. It is held until the next capture.
- R8: `blk_start` goes high in the cycle after the BLK_DELAY-th frame that follows a block mark. It stays high for BLK_LEN frames and goes low after the (BLK_DELAY+BLK_LEN)-th frame.
- R9: A block mark that arrives while the window is open or pending restarts the delay. `blk_start` is low in the cycle after the mark.
- R10: After reset, `out_valid`, `burst_det`, `nonaudio` and `blk_start` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | One received subframe sample this cycle |
| in_data | input | WORD_W | Received sample word |
| in_chan_b | input | 1 | 0 = subframe A, 1 = subframe B |
| in_zpre | input | 1 | Block-opening mark (meaningful on subframe A) |
| in_cs | input | 1 | Channel-status bit carried by this subframe |
| cs_sel | input | 1 | Channel-status source: 0 = subframe A, 1 = subframe B |
| out_valid | output | 1 | Delayed sample valid |
| out_data | output | WORD_W | Delayed sample word, unchanged |
| burst_det | output | 1 | Burst marker seen within the hold window |
| nonaudio | output | 1 | Reported non-audio status |
| blk_start | output | 1 | Delayed block-start window |

## Verification
The bench builds the block with HOLD_FRAMES=8. With that value, hold expiry, reload of a running timer and the drop on the last frame all happen within a few dozen frames. BLK_DELAY=2 and BLK_LEN=16 stay at their defaults, so the full window, including its rising and falling frames, is walked frame by frame. The same is done for a block mark that arrives while the window is open. The near-miss pattern with five leading zeros and the broken-then-clean sequence put the restart rule of the sync machine to the test.

// File: rtl/nab_pkg.sv
package nab_pkg;

    localparam int SYNC_W = 16;

    typedef enum logic [2:0] {
        SY_IDLE = 3'd0,
        SY_Z1   = 3'd1,
        SY_Z2   = 3'd2,
        SY_Z3   = 3'd3,
        SY_Z4   = 3'd4,
        SY_M1   = 3'd5
    } sync_st_t;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_WAIT = 2'd1,
        BK_OPEN = 2'd2
    } blk_st_t;

    // Word the sync machine expects next, by state.
    function automatic logic [SYNC_W-1:0] sync_word(sync_st_t s);
        case (s)
            SY_Z4:   return 16'hF872;
            SY_M1:   return 16'h4E1F;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/nab_sync_fsm.sv
module nab_sync_fsm
    import nab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [SYNC_W-1:0] word,
    output logic              hit
);

    sync_st_t st, nxt;
    logic     is_zero;

    assign is_zero = (word == sync_word(SY_IDLE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SY_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        hit = 1'b0;
        if (word_valid) begin
            unique case (st)
                SY_IDLE: nxt = is_zero ? SY_Z1 : SY_IDLE;
                SY_Z1:   nxt = is_zero ? SY_Z2 : SY_IDLE;
                SY_Z2:   nxt = is_zero ? SY_Z3 : SY_IDLE;
                SY_Z3:   nxt = is_zero ? SY_Z4 : SY_IDLE;
                SY_Z4: begin
                    if (word == sync_word(SY_Z4)) nxt = SY_M1;
                    else                          nxt = is_zero ? SY_Z1 : SY_IDLE;
                end
                SY_M1: begin
                    if (word == sync_word(SY_M1)) begin
                        hit = 1'b1;
                        nxt = SY_IDLE;
                    end else begin
                        nxt = is_zero ? SY_Z1 : SY_IDLE;
                    end
                end
                default: nxt = SY_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nab_hold_timer.sv
module nab_hold_timer #(
    parameter int HOLD_FRAMES = 4096,
    localparam int CW = $clog2(HOLD_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          frame_tick,
    output logic          active,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] FULL = CW'(HOLD_FRAMES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        count <= '0;
        else if (load)                     count <= FULL;
        else if (frame_tick && count != 0) count <= count - 1'b1;
    end

    assign active = (count != '0);

endmodule

// File: rtl/nab_block_fsm.sv
module nab_block_fsm
    import nab_pkg::*;
#(
    parameter int BLK_DELAY = 2,
    parameter int BLK_LEN   = 16,
    localparam int MX = (BLK_DELAY > BLK_LEN) ? BLK_DELAY : BLK_LEN,
    localparam int BW = $clog2(MX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic block_mark,
    output logic window
);

    localparam logic [BW-1:0] DLY_V = BW'(BLK_DELAY);
    localparam logic [BW-1:0] LEN_V = BW'(BLK_LEN);

    blk_st_t       st, nxt;
    logic [BW-1:0] cnt, cnt_nxt, cnt_inc;

    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = st;
        cnt_nxt = cnt;
        if (block_mark) begin
            nxt     = BK_WAIT;
            cnt_nxt = '0;
        end else if (frame_tick) begin
            unique case (st)
                BK_IDLE: nxt = BK_IDLE;
                BK_WAIT: begin
                    if (cnt_inc == DLY_V) begin
                        nxt     = BK_OPEN;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end
                BK_OPEN: begin
                    if (cnt_inc == LEN_V) begin
                        nxt     = BK_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end
                default: nxt = BK_IDLE;
            endcase
        end
    end

    assign window = (st == BK_OPEN);

endmodule

// File: rtl/nab_cs_capture.sv
module nab_cs_capture #(
    parameter int POS_W  = 8,
    parameter int CS_BIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic smp_chan_b,
    input  logic block_mark,
    input  logic smp_cs,
    input  logic cs_sel,
    output logic cs_flag
);

    localparam logic [POS_W-1:0] TGT = POS_W'(CS_BIT);

    logic [POS_W-1:0] fpos, cur_pos;
    logic             a_tick;

    assign a_tick = smp_valid && !smp_chan_b;

    // Position of the frame this subframe belongs to.
    always_comb begin
        if (!smp_chan_b) begin
            if (block_mark)        cur_pos = '0;
            else if (fpos == '1)   cur_pos = fpos;
            else                   cur_pos = fpos + 1'b1;
        end else begin
            cur_pos = fpos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fpos    <= '1;
            cs_flag <= 1'b0;
        end else begin
            if (a_tick) fpos <= cur_pos;
            if (smp_valid && (smp_chan_b == cs_sel) && (cur_pos == TGT))
                cs_flag <= smp_cs;
        end
    end

endmodule

// File: rtl/nab_detector.sv
module nab_detector
    import nab_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int HOLD_FRAMES = 4096,
    parameter int BLK_DELAY   = 2,
    parameter int BLK_LEN     = 16,
    parameter int CS_BIT      = 1,
    parameter int POS_W       = 8,
    localparam int CW = $clog2(HOLD_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_chan_b,
    input  logic              in_zpre,
    input  logic              in_cs,
    input  logic              cs_sel,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              burst_det,
    output logic              nonaudio,
    output logic              blk_start
);

    logic          frame_tick, block_mark, sync_hit, cs_flag;
    logic [CW-1:0] hold_cnt;

    assign frame_tick = in_valid && !in_chan_b;
    assign block_mark = frame_tick && in_zpre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

    nab_sync_fsm u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (in_valid),
        .word       (in_data[WORD_W-1 -: SYNC_W]),
        .hit        (sync_hit)
    );

    nab_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sync_hit),
        .frame_tick (frame_tick),
        .active     (burst_det),
        .count      (hold_cnt)
    );

    nab_cs_capture #(.POS_W(POS_W), .CS_BIT(CS_BIT)) u_cs (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (in_valid),
        .smp_chan_b (in_chan_b),
        .block_mark (in_zpre),
        .smp_cs     (in_cs),
        .cs_sel     (cs_sel),
        .cs_flag    (cs_flag)
    );

    nab_block_fsm #(.BLK_DELAY(BLK_DELAY), .BLK_LEN(BLK_LEN)) u_blk (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .block_mark (block_mark),
        .window     (blk_start)
    );

    assign nonaudio = burst_det || cs_flag;

endmodule

// File: rtl/nab_detector_chk.sv
module nab_detector_chk #(
    parameter int WORD_W      = 24,
    parameter int HOLD_FRAMES = 4096,
    localparam int CW = $clog2(HOLD_FRAMES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_data,
    input logic              in_chan_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              burst_det,
    input logic              nonaudio,
    input logic              blk_start,
    input logic              sync_hit,
    input logic [CW-1:0]     hold_cnt
);

    a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_data == $past(in_data)));

    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> burst_det);

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> (int'(hold_cnt) == HOLD_FRAMES));

    a_r4_fall_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(burst_det) |-> $past(in_valid && !in_chan_b && !sync_hit));

    a_r6_or: assert property (@(posedge clk) disable iff (!rst_n)
        burst_det |-> nonaudio);

    a_r8_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_start) |-> $past(in_valid && !in_chan_b));

endmodule

bind nab_detector nab_detector_chk #(
    .WORD_W(WORD_W), .HOLD_FRAMES(HOLD_FRAMES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_chan_b(in_chan_b), .out_valid(out_valid), .out_data(out_data),
    .burst_det(burst_det), .nonaudio(nonaudio), .blk_start(blk_start),
    .sync_hit(sync_hit), .hold_cnt(hold_cnt)
);

// File: tb/nab_detector_tb_top.sv
module nab_detector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        in_chan_b = 1'b0;
    logic        in_zpre = 1'b0;
    logic        in_cs = 1'b0;
    logic        cs_sel = 1'b0;
    logic        out_valid;
    logic [23:0] out_data;
    logic        burst_det, nonaudio, blk_start;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [23:0] exp_q[$];
    logic [23:0] fill = 24'h5A1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    nab_detector #(.HOLD_FRAMES(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_chan_b(in_chan_b), .in_zpre(in_zpre), .in_cs(in_cs),
        .cs_sel(cs_sel), .out_valid(out_valid), .out_data(out_data),
        .burst_det(burst_det), .nonaudio(nonaudio), .blk_start(blk_start)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: R1 scoreboard of passed-through samples.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected output", {8'h0, out_data}, 32'hFFFFFFFF);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check("R1 pass-through data", {8'h0, out_data}, {8'h0, e});
            end
        end
    end

    task automatic sub(input logic [23:0] d, input logic b, input logic z, input logic cs);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_chan_b = b; in_zpre = z; in_cs = cs;
        exp_q.push_back(d);
        @(negedge clk);
        in_valid = 1'b0; in_zpre = 1'b0;
    endtask

    task automatic frm(input logic [23:0] a, input logic [23:0] bw,
                       input logic z, input logic csa, input logic csb);
        sub(a, 1'b0, z, csa);
        sub(bw, 1'b1, 1'b0, csb);
    endtask

    task automatic filler_frames(input int n);
        for (int i = 0; i < n; i++) begin
            fill = fill + 24'h000101;
            frm(fill, fill ^ 24'h0F0F00, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    localparam logic [23:0] W0 = 24'h000000;
    localparam logic [23:0] WF = 24'hF87200;
    localparam logic [23:0] WE = 24'h4E1F00;

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 out_valid reset", out_valid, 0);
        check("R10 burst_det reset", burst_det, 0);
        check("R10 nonaudio reset", nonaudio, 0);
        check("R10 blk_start reset", blk_start, 0);
        rst_n = 1'b1;

        // R2: full marker
        frm(W0, W0, 0, 0, 0);
        frm(W0, W0, 0, 0, 0);
        sub(WF, 0, 0, 0);
        check("R2 no flag before last word", burst_det, 0);
        sub(WE, 1, 0, 0);
        check("R2 flag after marker", burst_det, 1);
        check("R6 nonaudio follows burst", nonaudio, 1);

        // R4: hold and expiry
        filler_frames(HOLD - 1);
        check("R4 flag held before expiry", burst_det, 1);
        sub(24'h3C3C00, 0, 0, 0);
        check("R4 flag dropped at expiry", burst_det, 0);
        check("R6 nonaudio low", nonaudio, 0);
        sub(24'h3C3D00, 1, 0, 0);

        // R5: reload while active
        frm(W0, W0, 0, 0, 0); frm(W0, W0, 0, 0, 0); frm(WF, WE, 0, 0, 0);
        filler_frames(4);
        frm(W0, W0, 0, 0, 0); frm(W0, W0, 0, 0, 0); frm(WF, WE, 0, 0, 0);
        filler_frames(HOLD - 1);
        check("R5 reloaded flag still high", burst_det, 1);
        sub(24'h3C3E00, 0, 0, 0);
        check("R5 flag drops after reloaded window", burst_det, 0);
        sub(24'h3C3F00, 1, 0, 0);

        // R3: five zeros then marker tail gives no match
        frm(W0, W0, 0, 0, 0); frm(W0, W0, 0, 0, 0);
        frm(W0, WF, 0, 0, 0); frm(WE, 24'h111100, 0, 0, 0);
        check("R3 five zeros no match", burst_det, 0);

        // R3: broken attempt then clean sequence matches (hit on subframe A)
        frm(W0, W0, 0, 0, 0); frm(24'h777700, W0, 0, 0, 0);
        frm(W0, W0, 0, 0, 0); frm(W0, WF, 0, 0, 0);
        sub(WE, 0, 0, 0);
        check("R3 restart then match", burst_det, 1);
        sub(24'h222200, 1, 0, 0);
        filler_frames(HOLD);
        check("R4 cleared before status tests", burst_det, 0);

        // R7: channel-status bit 1 from subframe A
        cs_sel = 1'b0;
        frm(24'h101000, 24'h101100, 1, 0, 0);
        sub(24'h101200, 0, 0, 1);
        check("R7 A-channel bit captured", nonaudio, 1);
        check("R6 burst still low", burst_det, 0);
        sub(24'h101300, 1, 0, 0);
        check("R7 B ignored when A selected", nonaudio, 1);
        frm(24'h101400, 24'h101500, 1, 0, 0);
        frm(24'h101600, 24'h101700, 0, 0, 1);
        check("R7 A bit cleared, B ignored", nonaudio, 0);
        cs_sel = 1'b1;
        frm(24'h101800, 24'h101900, 1, 0, 0);
        frm(24'h101A00, 24'h101B00, 0, 0, 1);
        check("R7 B-channel bit captured", nonaudio, 1);
        frm(24'h101C00, 24'h101D00, 0, 0, 0);
        check("R7 bit held outside frame 1", nonaudio, 1);
        frm(24'h101E00, 24'h101F00, 1, 0, 0);
        frm(24'h102000, 24'h102100, 0, 1, 0);
        check("R7 B bit cleared", nonaudio, 0);

        // R8: window timing
        sub(24'h200000, 0, 1, 0);
        check("R8 low after block mark", blk_start, 0);
        sub(24'h200100, 1, 0, 0);
        for (int f = 1; f <= 20; f++) begin
            sub(24'h210000 + 24'(f << 8), 0, 0, 0);
            check($sformatf("R8 window frame %0d", f), blk_start, (f >= 2 && f <= 17) ? 1 : 0);
            sub(24'h220000 + 24'(f << 8), 1, 0, 0);
        end

        // R9: restart while open
        frm(24'h300000, 24'h300100, 1, 0, 0);
        filler_frames(5);
        check("R9 window open before remark", blk_start, 1);
        sub(24'h310000, 0, 1, 0);
        check("R9 low after remark", blk_start, 0);
        sub(24'h310100, 1, 0, 0);
        frm(24'h320000, 24'h320100, 0, 0, 0);
        check("R9 still low one frame later", blk_start, 0);
        sub(24'h330000, 0, 0, 0);
        check("R9 reopens after delay", blk_start, 1);
        sub(24'h330100, 1, 0, 0);

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule